// File: doc/BRIEF.md
# Dual Split Decade Counter

This block holds two independent counting units. Each unit has a one-bit halving stage and a separate modulo-5 stage, and each stage is advanced by a falling transition on its own tick input. The tick inputs are ordinary data signals, not clocks. The block samples them on the system clock, finds the high-to-low transitions, and turns each one into a clock-enable pulse for the stage concerned. Each unit also has a clear input. While the clear is high, that unit's outputs read zero within the same cycle, and its state is held at zero on every clock edge.

External wiring decides what each unit counts. If the halving output drives the modulo-5 tick, the unit counts a decade in plain BCD. If the top quinary bit drives the halving tick, the unit gives a bi-quinary count whose lowest bit is a symmetric divide-by-ten square wave. A BCD unit whose top bit drives the second unit forms a divide-by-100 chain. Each link in such a chain adds a fixed sampling delay, so outputs further down the chain settle later. Combinations decoded from the outputs can therefore show short false values between those updates.

Top module: `split_decade_pair`

## Requirements
- R1: After `rst_n` is released, every bit of `count_o` is 0, and every stage state is 0 on the first enabled clock.
- R2: The halving stage of a unit inverts its bit on each detected falling transition of its `tick2_i` input. A rising transition has no effect.
- R3: The quinary stage of a unit steps through the codes 0, 1, 2, 3, 4 and then back to 0, one step per detected falling transition of its `tick5_i` input.
- R4: The quinary field never presents the codes 5, 6 or 7. A state outside 0 to 4 goes to 0 on the next enabled step.
- R5: While `clear_i[u]` is high, the four bits of unit u on `count_o` read 0 in the same cycle. The unit's state is forced to 0 on every clock edge, and falling ticks are ignored.
- R6: After `clear_i[u]` falls, unit u counts up again from 0.
- R7: The units are independent. Ticks and clears applied to one unit leave the other unit's outputs unchanged.
- R8: For unit u, `count_o[4u]` is the halving bit. `count_o[4u+3:4u+1]` is the quinary code, with bit 4u+3 as its most significant bit.
- R9: With the halving bit wired to the unit's `tick5_i`, the four bits of unit u read the number of input falls modulo 10, in binary.
- R10: With the top quinary bit wired to the unit's `tick2_i` and input falls applied on `tick5_i`, the quinary code equals the number of falls modulo 5. The halving bit equals (falls / 5) modulo 2.
- R11: With unit 0 in BCD wiring, its top bit driving unit 1's `tick2_i`, and unit 1 also in BCD wiring, the two units read the ones and tens digits of the number of falls, modulo 100.
- R12: A tick input is first sampled low at some clock edge. The state changes at the clock edge SYNC_DEPTH edges later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; takes effect at once, releases in step with `clk` |
| tick2_i | input | UNITS | Per-unit tick for the halving stage; a falling transition advances the stage |
| tick5_i | input | UNITS | Per-unit tick for the quinary stage; a falling transition advances the stage |
| clear_i | input | UNITS | Per-unit clear, active high |
| count_o | output | 4*UNITS | Per-unit four-bit state: halving bit in the low position, quinary code above it |

## Verification
The hardest situation to reach is the full divide-by-100 chain. There, the tens digit moves only after a falling transition has passed through four stages in sequence, each adding its own sampling delay. The bench wires the outputs back into the tick inputs, exactly as a user would. It holds each input level long enough for that chain to settle, and drives more than one hundred input falls so that both digits wrap. A clear in the middle of a count is also timed so that a halving bit drops to 0 while a downstream falling transition is still pending. This checks that the pending transition is ignored while the clear is high.

// File: rtl/split_decade_pkg.sv
package split_decade_pkg;
  localparam int QUINT_W = 3;
  localparam int DIGIT_W = QUINT_W + 1;

  typedef logic [QUINT_W-1:0] quint_t;

  localparam quint_t QUINT_TOP = quint_t'(4);

  typedef struct packed {
    quint_t quin;
    logic   half;
  } digit_t;

  // Modulo-5 successor; any code at or above the top wraps to zero.
  function automatic quint_t quint_next(input quint_t cur);
    return (cur >= QUINT_TOP) ? '0 : cur + quint_t'(1);
  endfunction
endpackage

// File: rtl/sdp_rst_sync.sv
module sdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/sdp_fall_detect.sv
module sdp_fall_detect #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC_DEPTH-1:0] sync_q;
  logic [SYNC_DEPTH-1:0] sync_d;
  logic                  prev_q;
  logic                  prev_d;

  generate
    if (SYNC_DEPTH == 1) begin : g_one
      always_comb sync_d = pin_i;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_DEPTH-2:0], pin_i};
    end
  endgenerate

  always_comb prev_d = sync_q[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_DEPTH-1];
endmodule

// File: rtl/sdp_half_stage.sv
module sdp_half_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic adv_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic en;

  always_comb begin
    en  = clear_i | adv_i;
    q_d = clear_i ? 1'b0 : ~q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= 1'b0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sdp_quint_stage.sv
module sdp_quint_stage
  import split_decade_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear_i,
  input  logic   adv_i,
  output quint_t q_o
);
  quint_t q_q;
  quint_t q_d;
  logic   en;

  always_comb begin
    en  = clear_i | adv_i;
    q_d = clear_i ? '0 : quint_next(q_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sdp_unit.sv
module sdp_unit
  import split_decade_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick2_i,
  input  logic   tick5_i,
  input  logic   clear_i,
  output digit_t state_o
);
  logic   fall2;
  logic   fall5;
  logic   half_q;
  quint_t quin_q;

  sdp_fall_detect #(.SYNC_DEPTH(SYNC_DEPTH)) u_det2 (
    .clk(clk), .rst_n(rst_n), .pin_i(tick2_i), .fall_o(fall2)
  );

  sdp_fall_detect #(.SYNC_DEPTH(SYNC_DEPTH)) u_det5 (
    .clk(clk), .rst_n(rst_n), .pin_i(tick5_i), .fall_o(fall5)
  );

  sdp_half_stage u_half (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .adv_i(fall2), .q_o(half_q)
  );

  sdp_quint_stage u_quin (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .adv_i(fall5), .q_o(quin_q)
  );

  always_comb begin
    state_o.half = half_q;
    state_o.quin = quin_q;
  end
endmodule

// File: rtl/split_decade_pair.sv
module split_decade_pair
  import split_decade_pkg::*;
#(
  parameter int UNITS      = 2,
  parameter int SYNC_DEPTH = 2,
  parameter int RST_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [UNITS-1:0]         tick2_i,
  input  logic [UNITS-1:0]         tick5_i,
  input  logic [UNITS-1:0]         clear_i,
  output logic [UNITS*DIGIT_W-1:0] count_o
);
  localparam int CW = UNITS * DIGIT_W;

  logic          rst_ok;
  logic [CW-1:0] raw_state;

  sdp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_ok)
  );

  generate
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      digit_t st;

      sdp_unit #(.SYNC_DEPTH(SYNC_DEPTH)) u_unit (
        .clk(clk), .rst_n(rst_ok),
        .tick2_i(tick2_i[u]), .tick5_i(tick5_i[u]), .clear_i(clear_i[u]),
        .state_o(st)
      );

      assign raw_state[u*DIGIT_W +: DIGIT_W] = st;
      // Clear masks the unit's outputs in the same cycle it is raised.
      assign count_o[u*DIGIT_W +: DIGIT_W]   = clear_i[u] ? '0 : st;
    end
  endgenerate
endmodule

// File: rtl/split_decade_pair_chk.sv
module split_decade_pair_chk
  import split_decade_pkg::*;
#(
  parameter int UNITS = 2
) (
  input logic                     clk,
  input logic                     rst_ok,
  input logic [UNITS-1:0]         clear_i,
  input logic [UNITS*DIGIT_W-1:0] raw_state,
  input logic [UNITS*DIGIT_W-1:0] count_o
);
  generate
    for (genvar u = 0; u < UNITS; u++) begin : g_chk
      assert_release_zero_R1: assert property (@(posedge clk)
        $rose(rst_ok) |-> (raw_state[u*DIGIT_W +: DIGIT_W] == '0));

      assert_quint_step_R3: assert property (@(posedge clk) disable iff (!rst_ok)
        (!$stable(raw_state[u*DIGIT_W+1 +: QUINT_W]) && !$past(clear_i[u]))
        |-> (raw_state[u*DIGIT_W+1 +: QUINT_W] ==
             (($past(raw_state[u*DIGIT_W+1 +: QUINT_W]) == QUINT_TOP) ? quint_t'(0)
              : quint_t'($past(raw_state[u*DIGIT_W+1 +: QUINT_W]) + quint_t'(1)))));

      assert_quint_legal_R4: assert property (@(posedge clk) disable iff (!rst_ok)
        raw_state[u*DIGIT_W+1 +: QUINT_W] <= QUINT_TOP);

      assert_clear_masks_R5: assert property (@(posedge clk) disable iff (!rst_ok)
        clear_i[u] |-> (count_o[u*DIGIT_W +: DIGIT_W] == '0));

      assert_clear_holds_R5: assert property (@(posedge clk) disable iff (!rst_ok)
        clear_i[u] |=> (raw_state[u*DIGIT_W +: DIGIT_W] == '0));

      assert_resume_zero_R6: assert property (@(posedge clk) disable iff (!rst_ok)
        $fell(clear_i[u]) |-> (raw_state[u*DIGIT_W +: DIGIT_W] == '0));
    end
  endgenerate
endmodule

bind split_decade_pair split_decade_pair_chk #(.UNITS(UNITS)) u_chk (
  .clk(clk), .rst_ok(rst_ok), .clear_i(clear_i),
  .raw_state(raw_state), .count_o(count_o)
);

// File: tb/test_split_decade_pair.sv
module test_split_decade_pair;
  localparam int UNITS = 2;
  localparam int DEPTH = 2;
  localparam int LIMIT = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] t2, t5, clr, src2, src5;
  logic [7:0] cnt;
  int         mode;   // 0 free, 1 BCD, 2 bi-quinary, 3 hundred chain
  int         checks = 0;
  int         errors = 0;
  string      phase = "R1";

  int m2 [2];
  int m5 [2];
  bit hq [4][$];

  always #10 clk = ~clk;

  split_decade_pair #(.UNITS(UNITS), .SYNC_DEPTH(DEPTH)) i_split_decade_pair (
    .clk(clk), .rst_n(rst_n), .tick2_i(t2), .tick5_i(t5), .clear_i(clr), .count_o(cnt)
  );

  always_comb begin
    t2 = src2;
    t5 = src5;
    case (mode)
      1: begin t5[0] = cnt[0]; t5[1] = cnt[4]; end
      2: begin t2[0] = cnt[3]; t2[1] = cnt[7]; end
      3: begin t5[0] = cnt[0]; t2[1] = cnt[3]; t5[1] = cnt[4]; end
      default: ;
    endcase
  end

  function automatic logic [3:0] mout(int u);
    logic [2:0] qv;
    qv = 3'(m5[u]);
    return clr[u] ? 4'h0 : {qv, m2[u][0]};
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin
      hq[s].delete();
      for (int k = 0; k < DEPTH + 2; k++) hq[s].push_back(1'b0);
    end
    for (int u = 0; u < 2; u++) begin m2[u] = 0; m5[u] = 0; end
  endtask

  task automatic model_step();
    logic [7:0] mo;
    bit pin [4];
    bit fall [4];
    mo = {mout(1), mout(0)};
    pin[0] = src2[0]; pin[1] = src5[0]; pin[2] = src2[1]; pin[3] = src5[1];
    case (mode)
      1: begin pin[1] = mo[0]; pin[3] = mo[4]; end
      2: begin pin[0] = mo[3]; pin[2] = mo[7]; end
      3: begin pin[1] = mo[0]; pin[2] = mo[3]; pin[3] = mo[4]; end
      default: ;
    endcase
    for (int s = 0; s < 4; s++) begin
      hq[s].push_front(pin[s]);
      void'(hq[s].pop_back());
      fall[s] = hq[s][DEPTH+1] && !hq[s][DEPTH];
    end
    for (int u = 0; u < 2; u++) begin
      if (clr[u]) begin m2[u] = 0; m5[u] = 0; end
      else begin
        if (fall[2*u])   m2[u] = m2[u] ^ 1;
        if (fall[2*u+1]) m5[u] = (m5[u] == 4) ? 0 : m5[u] + 1;
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    model_step();
    chk(phase, 32'(cnt), 32'({mout(1), mout(0)}));
    chk("R4", 32'(cnt[3:1] <= 3'd4 && cnt[7:5] <= 3'd4), 32'd1);
  endtask

  task automatic pulse(int u, bit five, int half);
    if (five) src5[u] = 1'b1; else src2[u] = 1'b1;
    repeat (half) cyc();
    if (five) src5[u] = 1'b0; else src2[u] = 1'b0;
    repeat (half) cyc();
  endtask

  task automatic clear_all(int new_mode);
    clr = 2'b11;
    repeat (3) cyc();
    mode = new_mode;
    repeat (10) cyc();
    clr = 2'b00;
    repeat (4) cyc();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", LIMIT);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode = 0; src2 = '0; src5 = '0; clr = '0;
    model_reset();
    repeat (5) @(negedge clk);
    chk("R1", 32'(cnt), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", 32'(cnt), 32'h0);

    // R12 / R2: latency of one fall, rising edge ignored
    phase = "R12";
    src2[0] = 1'b1;
    repeat (4) cyc();
    chk("R2", 32'(cnt[0]), 32'd0);
    src2[0] = 1'b0;
    repeat (DEPTH) cyc();
    chk("R12", 32'(cnt[0]), 32'd0);
    cyc();
    chk("R12", 32'(cnt[0]), 32'd1);
    repeat (4) cyc();

    // R3 / R7: quinary sequence on unit 0, unit 1 untouched
    phase = "R3";
    for (int i = 1; i <= 6; i++) begin
      pulse(0, 1'b1, 8);
      chk("R3", 32'(cnt[3:1]), 32'(i % 5));
      chk("R7", 32'(cnt[7:4]), 32'h0);
    end

    // R8: field layout on unit 1
    phase = "R8";
    pulse(1, 1'b1, 8);
    chk("R8", 32'(cnt[7:4]), 32'h2);
    pulse(1, 1'b0, 8);
    chk("R8", 32'(cnt[7:4]), 32'h3);

    // R9: BCD decade on both units
    phase = "R9";
    clear_all(1);
    for (int i = 1; i <= 23; i++) begin
      pulse(0, 1'b0, 8);
      chk("R9", 32'(cnt[3:0]), 32'(i % 10));
    end
    for (int i = 1; i <= 4; i++) pulse(1, 1'b0, 8);
    chk("R9", 32'(cnt[7:4]), 32'd4);

    // R5 / R6 / R7: clear in mid-count
    phase = "R5";
    clr[0] = 1'b1;
    #1;
    chk("R5", 32'(cnt[3:0]), 32'h0);
    chk("R7", 32'(cnt[7:4]), 32'd4);
    for (int i = 0; i < 3; i++) begin
      pulse(0, 1'b0, 8);
      chk("R5", 32'(cnt[3:0]), 32'h0);
    end
    clr[0] = 1'b0;
    repeat (4) cyc();
    chk("R6", 32'(cnt[3:0]), 32'h0);
    phase = "R6";
    for (int i = 1; i <= 3; i++) pulse(0, 1'b0, 8);
    chk("R6", 32'(cnt[3:0]), 32'd3);
    chk("R7", 32'(cnt[7:4]), 32'd4);

    // R10: bi-quinary on unit 0
    phase = "R10";
    clear_all(2);
    for (int i = 1; i <= 21; i++) begin
      pulse(0, 1'b1, 16);
      chk("R10", 32'(cnt[3:0]), 32'((i % 5) * 2 + (i / 5) % 2));
    end

    // R11: divide-by-100 chain
    phase = "R11";
    clear_all(3);
    for (int i = 1; i <= 105; i++) begin
      pulse(0, 1'b0, 16);
      chk("R11", 32'(cnt), 32'((((i / 10) % 10) << 4) | (i % 10)));
    end

    finish_run();
  end
endmodule